// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block translates a 14-bit virtual address into a 12-bit physical address by fetching one page table entry from memory. A requester presents the virtual address and an access type (read or write) with a valid/ready handshake. The walker adds the virtual page number, scaled to the entry size, to the table base it sampled with the request. It issues one single-word read on a simple memory port and waits for the returned word, which may arrive after any number of cycles.

The returned entry is decoded for residency and for its read and write rights. The walker then holds either a physical address or a fault code on its response port until the consumer takes it. Only one request is in flight at a time. A page fault or protection fault is reported so that the surrounding logic can trap to system software. The walker itself does not service faults.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: For each accepted request, `mem_rd_en` is high for exactly one cycle, with `mem_addr` equal to the sampled base plus twice the virtual page number (virtual address bits 13:6).
- R3: An entry word has the resident bit at bit 15, the read right at bit 14, the write right at bit 13 and the frame number in bits 5:0. For a resident entry whose right permits the access, `rsp_fault` is 2'b00 and `rsp_paddr` is {frame, virtual address bits 5:0}. For example, 0x03D4 with entry 0x0F holding frame 0x0D gives 0x354.
- R4: If the entry's resident bit is 0, `rsp_fault` is 2'b01 (page fault) and `rsp_paddr` is 0.
- R5: A resident entry that denies the access gives `rsp_fault` 2'b10 (protection fault) and `rsp_paddr` 0. A read is denied when bit 14 is 0, and a write when bit 13 is 0.
- R6: When an entry is both non-resident and lacks the requested right, the page fault code 2'b01 is reported.
- R7: From acceptance until the response is taken, `req_ready` is 0, no second request is accepted, and exactly one memory read is issued per request.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid with `rsp_paddr` and `rsp_fault` unchanged.
- R9: `table_base` is sampled when the request is accepted. Later changes to it do not affect the entry address of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_base | input | 16 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_en | output | 1 | One-cycle read strobe for the entry |
| mem_addr | output | 16 | Byte address of the entry |
| mem_rd_valid | input | 1 | Entry word is present on mem_rd_data |
| mem_rd_data | input | 16 | Entry word returned by memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 12 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
Two faults can apply to one entry in the same decode: the entry is non-resident and also lacks the right for the requested access. This case is provoked with an entry word that has its resident bit and both right bits cleared, and another that is non-resident with rights set. Both reads and writes are sent to them. The response is judged correct only if it carries the page fault code and a zero address. A scoreboard checks the separate protection-only entries, so that a swapped priority shows up as a wrong code.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } ptw_state_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } ptw_fault_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VPN_W     = 8,
  parameter int MEM_AW    = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic [MEM_AW-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [MEM_AW-1:0] entry_addr
);

  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [MEM_AW-1:0] vpn_ext;
  assign vpn_ext = {{(MEM_AW-VPN_W){1'b0}}, vpn};

  generate
    if (SHIFT == 0) begin : g_byte_entry
      assign entry_addr = base + vpn_ext;
    end else begin : g_wide_entry
      assign entry_addr = base + (vpn_ext << SHIFT);
    end
  endgenerate

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 16,
  parameter int PPN_W = 6,
  parameter int OFF_W = 6
) (
  input  logic [PTE_W-1:0]       pte,
  input  logic                   is_write,
  input  logic [OFF_W-1:0]       offset,
  output ptw_fault_e             fault,
  output logic [PPN_W+OFF_W-1:0] paddr
);

  localparam int RES_BIT = PTE_W - 1;
  localparam int RD_BIT  = PTE_W - 2;
  localparam int WR_BIT  = PTE_W - 3;

  logic resident;
  logic may_read;
  logic may_write;
  logic denied;
  logic unused_rsvd;

  assign resident    = pte[RES_BIT];
  assign may_read    = pte[RD_BIT];
  assign may_write   = pte[WR_BIT];
  assign denied      = is_write ? !may_write : !may_read;
  assign unused_rsvd = ^pte[WR_BIT-1:PPN_W];

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!resident) begin
      fault = FLT_PAGE;
    end else if (denied) begin
      fault = FLT_PROT;
    end else begin
      paddr = {pte[PPN_W-1:0], offset};
    end
  end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic mem_rd_en,
  output logic capture,
  output logic rsp_valid
);

  ptw_state_e state_q;
  ptw_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)    state_d = ST_FETCH;
      ST_FETCH:                   state_d = ST_WAIT;
      ST_WAIT:  if (mem_rd_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign mem_rd_en = (state_q == ST_FETCH);
  assign capture   = (state_q == ST_WAIT) && mem_rd_valid;
  assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int MEM_AW    = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] table_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic              accept;
  logic              capture;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic [MEM_AW-1:0] base_q;
  logic [PA_W-1:0]   paddr_q;
  ptw_fault_e        fault_q;
  ptw_fault_e        fault_d;
  logic [PA_W-1:0]   paddr_d;

  ptw_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_valid (mem_rd_valid),
    .rsp_ready    (rsp_ready),
    .req_ready    (req_ready),
    .accept       (accept),
    .mem_rd_en    (mem_rd_en),
    .capture      (capture),
    .rsp_valid    (rsp_valid)
  );

  ptw_addr_gen #(
    .VPN_W     (VPN_W),
    .MEM_AW    (MEM_AW),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .base       (base_q),
    .vpn        (vaddr_q[VA_W-1:OFF_W]),
    .entry_addr (mem_addr)
  );

  ptw_pte_check #(
    .PTE_W (PTE_W),
    .PPN_W (PPN_W),
    .OFF_W (OFF_W)
  ) u_check (
    .pte      (mem_rd_data),
    .is_write (write_q),
    .offset   (vaddr_q[OFF_W-1:0]),
    .fault    (fault_d),
    .paddr    (paddr_d)
  );

  // request capture: enabled by the handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      write_q <= 1'b0;
      base_q  <= '0;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr;
        write_q <= req_write;
        base_q  <= table_base;
      end
    end
  end

  // result capture: enabled by the returned entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      if (capture) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
      end
    end
  end

  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int MEM_AW    = 16,
  parameter int PTE_BYTES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MEM_AW-1:0] table_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [1:0]        rsp_fault
);

  localparam int VPN_W = VA_W - OFF_W;

  logic [OFF_W-1:0]  off_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [MEM_AW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      vpn_q  <= '0;
      base_q <= '0;
    end else if (req_valid && req_ready) begin
      off_q  <= req_vaddr[OFF_W-1:0];
      vpn_q  <= req_vaddr[VA_W-1:OFF_W];
      base_q <= table_base;
    end
  end

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_entry_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_addr == base_q + MEM_AW'(vpn_q) * MEM_AW'(PTE_BYTES));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == off_q);

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);

  assert_fault_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

bind pt_walker ptw_checker #(
  .VA_W      (VA_W),
  .PA_W      (PA_W),
  .OFF_W     (OFF_W),
  .MEM_AW    (MEM_AW),
  .PTE_BYTES (PTE_BYTES)
) u_ptw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .table_base (table_base),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk;
  logic        rst_n;
  logic [15:0] table_base;
  logic        req_valid;
  logic        req_ready;
  logic [13:0] req_vaddr;
  logic        req_write;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic        mem_rd_valid;
  logic [15:0] mem_rd_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [11:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  pt_walker i_pt_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .table_base   (table_base),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_write    (req_write),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  int reads    = 0;
  int sent     = 0;
  int mem_lat  = 1;
  bit bp_mode  = 1'b0;
  logic [15:0] cur_base = 16'h0000;

  logic [15:0] bmem [0:511];
  logic [13:0] exp_q  [$];
  logic [15:0] addr_q [$];
  string       tag_q  [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected result from the entry layout: {fault[1:0], paddr[11:0]}
  function automatic logic [13:0] model(input logic [15:0] base,
                                        input logic [13:0] va, input bit wr);
    logic [15:0] ea;
    logic [15:0] w;
    ea = base + {7'b0, va[13:6], 1'b0};
    w  = bmem[ea[9:1]];
    if (!w[15])                  return {2'b01, 12'h000};
    if (wr ? !w[13] : !w[14])    return {2'b10, 12'h000};
    return {2'b00, w[5:0], va[5:0]};
  endfunction

  task automatic send(input logic [13:0] va, input bit wr, input string tag,
                      input bit junk);
    logic [15:0] ea;
    @(negedge clk);
    table_base = cur_base;
    ea = cur_base + {7'b0, va[13:6], 1'b0};
    exp_q.push_back(model(cur_base, va, wr));
    addr_q.push_back(ea);
    tag_q.push_back(tag);
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    sent++;
    if (junk) table_base = 16'h0100;
  endtask

  // memory responder
  initial begin
    logic [15:0] a;
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_en) begin
        a = mem_addr;
        reads++;
        if (addr_q.size() != 0) begin
          logic [15:0] e;
          e = addr_q.pop_front();
          check(a == e, "R2", "entry address", a, e);
        end else begin
          check(1'b0, "R7", "read without request", a, 0);
        end
        @(negedge clk);
        check(!mem_rd_en, "R2", "read strobe width", mem_rd_en, 0);
        repeat (mem_lat - 1) @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = bmem[a[9:1]];
        @(negedge clk);
        mem_rd_valid = 1'b0;
      end
    end
  end

  // response monitor / scoreboard
  initial begin
    bit          held;
    logic [11:0] h_pa;
    logic [1:0]  h_f;
    int          cyc;
    held = 1'b0; h_pa = '0; h_f = '0; cyc = 0;
    rsp_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held)
          check(rsp_valid && rsp_paddr == h_pa && rsp_fault == h_f, "R8",
                "response held", {rsp_valid, rsp_fault, rsp_paddr}, {1'b1, h_f, h_pa});
        rsp_ready = bp_mode ? (cyc % 3 == 2) : 1'b1;
        cyc++;
        if (rsp_valid) check(!req_ready, "R7", "ready low while busy", req_ready, 0);
        if (rsp_valid && rsp_ready) begin
          held = 1'b0;
          if (exp_q.size() != 0) begin
            logic [13:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({rsp_fault, rsp_paddr} == e, t, "fault/paddr",
                  {rsp_fault, rsp_paddr}, e);
          end else begin
            check(1'b0, "R7", "unexpected response", rsp_paddr, 0);
          end
        end else if (rsp_valid) begin
          held = 1'b1; h_pa = rsp_paddr; h_f = rsp_fault;
        end else begin
          held = 1'b0;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      logic [7:0] v;
      logic [5:0] p;
      v = i[7:0];
      p = (i < 256) ? (v[5:0] ^ 6'h2A) : (v[5:0] ^ 6'h15);
      bmem[i] = {2'b11, ~v[0], 7'b0, p};
    end
    bmem[9'h00F] = {3'b111, 7'b0, 6'h0D};
    bmem[9'h001] = {3'b011, 7'b0, 6'h3F};
    bmem[9'h020] = {3'b100, 7'b0, 6'h11};
    bmem[9'h021] = {3'b000, 7'b0, 6'h12};
    bmem[9'h022] = {3'b101, 7'b0, 6'h13};
    bmem[9'h023] = {3'b110, 7'b0, 6'h14};

    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    table_base = 16'h0000;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R1", "in reset",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd_en, "R1", "after reset",
          {req_ready, rsp_valid, mem_rd_en}, 3'b100);

    // R3 known translation, both access types
    send(14'h03D4, 1'b0, "R3", 1'b0);
    send(14'h03D4, 1'b1, "R3", 1'b0);
    // R4 non-resident page
    send({8'h01, 6'h15}, 1'b0, "R4", 1'b0);
    send({8'h01, 6'h3F}, 1'b1, "R4", 1'b0);
    // R5 rights
    send({8'h20, 6'h01}, 1'b0, "R5", 1'b0);
    send({8'h20, 6'h02}, 1'b1, "R5", 1'b0);
    send({8'h22, 6'h03}, 1'b0, "R5", 1'b0);
    send({8'h22, 6'h04}, 1'b1, "R5", 1'b0);
    send({8'h23, 6'h05}, 1'b1, "R5", 1'b0);
    send({8'h23, 6'h06}, 1'b0, "R5", 1'b0);
    // R6 both faults on one entry
    send({8'h21, 6'h07}, 1'b0, "R6", 1'b0);
    send({8'h21, 6'h08}, 1'b1, "R6", 1'b0);
    send({8'h01, 6'h09}, 1'b1, "R6", 1'b0);

    // R7 / R8 back-to-back with backpressure and longer latency
    bp_mode = 1'b1;
    mem_lat = 3;
    for (int k = 0; k < 12; k++)
      send({k[7:0] * 8'd21 + 8'd5, k[5:0] ^ 6'h2B}, k[0], "R7", 1'b0);
    mem_lat = 1;
    bp_mode = 1'b0;

    // R9 second table, base changed after acceptance
    cur_base = 16'h0200;
    for (int k = 0; k < 6; k++)
      send({k[7:0] * 8'd37 + 8'd2, k[5:0]}, k[1], "R9", 1'b1);
    cur_base = 16'h0000;

    // spread of pages across the table
    mem_lat = 2;
    for (int k = 0; k < 16; k++)
      send({k[7:0] * 8'd16 + 8'd15, 6'h2A - k[5:0]}, k[2], "R3", 1'b0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(reads == sent, "R7", "one read per request", reads, sent);
    check(req_ready && !rsp_valid, "R7", "idle at end",
          {req_ready, rsp_valid}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule